// File: doc/BRIEF.md
# Multi-Preset Streaming CRC Engine

This block computes a CRC over a byte stream of any length, or checks a stream against an expected CRC. One of four fixed algorithm presets is chosen: a 32-bit Ethernet-style CRC, a 16-bit CCITT CRC, an 8-bit J1850-style CRC and an 8-bit CRC with polynomial 0x2F. Each preset has its own width, polynomial, initial value, bit ordering and output inversion. Software picks a preset and strobes `start`, which arms the unit. It then pushes bytes through a valid/ready port at up to one byte per clock and marks the last beat with `last`. The finished CRC appears on `crc_out` together with a sticky `done` flag.

In verify mode, the finished CRC is compared with `expect_crc` when the last beat is taken. The outcome is reported on `match` or `mismatch`. Each instance keeps all of its state to itself, so up to eight copies can sit side by side with nothing shared between them.

Top module: `crc_multi_unit`

## Requirements
- R1: While reset is held, and after it is released, `in_ready`, `done`, `match` and `mismatch` are 0 and `crc_out` is 0 until the first `start`.
- R2: Preset code 0 gives the 32-bit CRC: polynomial 0x04C11DB7, initial value 0xFFFFFFFF, reflected input and output, final XOR 0xFFFFFFFF. Over the ASCII bytes "123456789" the result is 0xCBF43926.
- R3: Preset code 1 gives the 16-bit CRC: polynomial 0x1021, initial value 0xFFFF, MSB first, no final XOR. Over "123456789" the result is 0x29B1.
- R4: Preset code 2 gives the 8-bit CRC with polynomial 0x1D: initial value 0xFF, MSB first, final XOR 0xFF. Over "123456789" the result is 0x4B.
- R5: Preset code 3 gives the 8-bit CRC with polynomial 0x2F: initial value 0xFF, MSB first, final XOR 0xFF. Over "123456789" the result is 0xDF.
- R6: A byte is absorbed on each clock edge where both `in_valid` and `in_ready` are 1. Cycles with `in_valid` low leave the CRC unchanged.
- R7: `start` latches `preset_sel` and `verify_en`, clears `done`, `match`, `mismatch` and `crc_out`, and raises `in_ready` in the next cycle. A change of `preset_sel` during a frame has no effect on that frame. If `start` and `last` arrive together, `start` wins.
- R8: A beat taken with `last` = 1 is included in the CRC, and `last` may be given with `in_valid` = 0 to close a frame with no further byte. In the next cycle `done` is 1 and `in_ready` is 0. `crc_out` holds the result, zero-extended for the narrow presets, until the next `start`.
- R9: Bytes and `last` presented while `in_ready` is 0 are ignored: `crc_out` and `done` do not change.
- R10: In verify mode, `match` (or else `mismatch`) rises together with `done`. Only the low preset-width bits of `expect_crc` take part in the compare.
- R11: In generate mode, `match` and `mismatch` stay 0.
- R12: A frame with no bytes yields the finalized initial value: 0x00000000, 0xFFFF, 0x00 and 0x00 for presets 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| preset_sel | input | 2 | Preset code, taken at `start` |
| verify_en | input | 1 | 1 selects check mode, taken at `start` |
| start | input | 1 | Arms the unit and loads the initial value |
| in_valid | input | 1 | Byte present on `in_data` |
| in_data | input | 8 | Stream byte |
| last | input | 1 | Marks the final beat of the frame |
| in_ready | output | 1 | Unit accepts bytes |
| expect_crc | input | 32 | Reference CRC for check mode, sampled on the last beat |
| crc_out | output | 32 | Finished CRC, zero-extended |
| done | output | 1 | Result valid, sticky until `start` |
| match | output | 1 | Check mode: result equals reference |
| mismatch | output | 1 | Check mode: result differs from reference |

## Verification
The assertions check on every cycle the handshake invariants: `in_ready` follows `start` and drops once `done` is set, and `crc_out` stays stable while `done` holds. They also check that `match` and `mismatch` are never both high, that both stay low in generate mode, and that the upper bits are zero for narrow presets. Only the bench scenarios can show that the arithmetic is right. They run the known check strings, streams with bubbles, empty frames, a preset change in the middle of a frame, ignored traffic after completion, and compares where the expected value has junk in its upper bits.

// File: rtl/crc_multi_pkg.sv
// Package: shared types and per-preset constants for the CRC engine.
// Non-reflected presets are held left-aligned in a 32-bit register so a
// single shift network serves every width.
package crc_multi_pkg;

    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PRE_ETH32  = 2'd0,
        PRE_CCITT  = 2'd1,
        PRE_SAE8   = 2'd2,
        PRE_POLY2F = 2'd3
    } preset_t;

    // Width in bits of the CRC for a preset.
    function automatic int unsigned pre_width(preset_t p);
        case (p)
            PRE_ETH32: return 32;
            PRE_CCITT: return 16;
            default:   return 8;
        endcase
    endfunction

    // True when the preset shifts LSB first.
    function automatic logic pre_reflect(preset_t p);
        return (p == PRE_ETH32);
    endfunction

    // Polynomial in the shift direction the engine uses.
    function automatic logic [CRC_W-1:0] pre_poly(preset_t p);
        case (p)
            PRE_ETH32: return 32'hEDB8_8320;
            PRE_CCITT: return 32'h1021_0000;
            PRE_SAE8:  return 32'h1D00_0000;
            default:   return 32'h2F00_0000;
        endcase
    endfunction

    // Initial register contents, aligned like the polynomial.
    function automatic logic [CRC_W-1:0] pre_init(preset_t p);
        case (p)
            PRE_ETH32: return 32'hFFFF_FFFF;
            PRE_CCITT: return 32'hFFFF_0000;
            default:   return 32'hFF00_0000;
        endcase
    endfunction

    // Output inversion mask, right-aligned.
    function automatic logic [CRC_W-1:0] pre_xorout(preset_t p);
        case (p)
            PRE_ETH32: return 32'hFFFF_FFFF;
            PRE_CCITT: return 32'h0000_0000;
            default:   return 32'h0000_00FF;
        endcase
    endfunction

    // Right-aligned mask covering the preset width.
    function automatic logic [CRC_W-1:0] pre_mask(preset_t p);
        case (p)
            PRE_ETH32: return 32'hFFFF_FFFF;
            PRE_CCITT: return 32'h0000_FFFF;
            default:   return 32'h0000_00FF;
        endcase
    endfunction

endpackage

// File: rtl/crc_byte_engine.sv
// Module: crc_byte_engine
// Advances the CRC register by one byte in a single combinational pass.
// Assumes the state uses the package layout: LSB-first presets right-aligned,
// MSB-first presets left-aligned in the 32-bit register.
module crc_byte_engine
    import crc_multi_pkg::*;
(
    input  preset_t                 preset,
    input  logic [CRC_W-1:0]        state_in,
    input  logic [BYTE_W-1:0]       data_in,
    output logic [CRC_W-1:0]        state_out
);

    localparam int LOW_PAD = CRC_W - BYTE_W;

    logic             refl;
    logic [CRC_W-1:0] poly;
    logic [CRC_W-1:0] stage [BYTE_W+1];

    // Folds the byte into the end of the register that shifts out first.
    always_comb begin
        refl     = pre_reflect(preset);
        poly     = pre_poly(preset);
        stage[0] = refl ? (state_in ^ {{LOW_PAD{1'b0}}, data_in})
                        : (state_in ^ {data_in, {LOW_PAD{1'b0}}});
    end

    // One shift-and-reduce step per data bit.
    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        always_comb begin
            if (refl)
                stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ poly) : (stage[b] >> 1);
            else
                stage[b+1] = stage[b][CRC_W-1] ? ((stage[b] << 1) ^ poly) : (stage[b] << 1);
        end
    end

    assign state_out = stage[BYTE_W];

endmodule

// File: rtl/crc_result.sv
// Module: crc_result
// Finalizes the register into a right-aligned CRC, compares it against the
// reference in verify mode, and holds result and flags until the next start.
// Assumes close and start are never high together (the controller gates this).
module crc_result
    import crc_multi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              close,
    input  preset_t           preset,
    input  logic              verify,
    input  logic [CRC_W-1:0]  final_state,
    input  logic [CRC_W-1:0]  expect_crc,
    output logic [CRC_W-1:0]  crc_out,
    output logic              done,
    output logic              match,
    output logic              mismatch
);

    logic [CRC_W-1:0] fin;
    logic             equal;

    // Maps the register into output form and compares under the width mask.
    always_comb begin
        if (pre_reflect(preset))
            fin = final_state ^ pre_xorout(preset);
        else
            fin = (final_state >> (CRC_W - pre_width(preset))) ^ pre_xorout(preset);
        equal = ((fin ^ expect_crc) & pre_mask(preset)) == '0;
    end

    // Result registers: cleared by start, loaded on the closing beat.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            crc_out  <= '0;
            done     <= 1'b0;
            match    <= 1'b0;
            mismatch <= 1'b0;
        end else if (close) begin
            crc_out  <= fin;
            done     <= 1'b1;
            match    <= verify && equal;
            mismatch <= verify && !equal;
        end
    end

    p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(match && mismatch));
    p_flags_need_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (match || mismatch) |-> done);
    p_result_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start && !close) |=> ($stable(crc_out) && done));

endmodule

// File: rtl/crc_multi_unit.sv
// Module: crc_multi_unit (top)
// Streaming CRC with four fixed presets and an optional check mode. start
// latches the preset and mode and loads the initial value. Each valid&ready
// beat absorbs one byte, and the beat or bubble carrying last closes the frame.
// Assumes the driver holds in_data stable while in_valid is high.
module crc_multi_unit
    import crc_multi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        preset_sel,
    input  logic              verify_en,
    input  logic              start,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              last,
    output logic              in_ready,
    input  logic [31:0]       expect_crc,
    output logic [31:0]       crc_out,
    output logic              done,
    output logic              match,
    output logic              mismatch
);

    preset_t          preset_q;
    logic             verify_q;
    logic             armed;
    logic [CRC_W-1:0] state_q;
    logic [CRC_W-1:0] state_step;
    logic [CRC_W-1:0] state_next;
    logic             take;
    logic             close;

    assign in_ready = armed;
    assign take     = armed && in_valid && !start;
    assign close    = armed && last && !start;

    crc_byte_engine u_engine (
        .preset    (preset_q),
        .state_in  (state_q),
        .data_in   (in_data),
        .state_out (state_step)
    );

    // Chooses the register value after this cycle's beat, if any.
    always_comb state_next = take ? state_step : state_q;

    // Frame control: arm on start, disarm on the closing beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            preset_q <= PRE_ETH32;
            verify_q <= 1'b0;
            state_q  <= '0;
        end else if (start) begin
            armed    <= 1'b1;
            preset_q <= preset_t'(preset_sel);
            verify_q <= verify_en;
            state_q  <= pre_init(preset_t'(preset_sel));
        end else begin
            state_q <= state_next;
            if (close)
                armed <= 1'b0;
        end
    end

    crc_result u_result (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .close       (close),
        .preset      (preset_q),
        .verify      (verify_q),
        .final_state (state_next),
        .expect_crc  (expect_crc),
        .crc_out     (crc_out),
        .done        (done),
        .match       (match),
        .mismatch    (mismatch)
    );

    p_ready_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (in_ready && !done));
    p_done_blocks_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);
    p_generate_no_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !verify_q) |-> (!match && !mismatch));
    p_narrow_zero_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && preset_q != PRE_ETH32) |-> (crc_out[31:16] == 16'h0));
    p_idle_state_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !start) |=> $stable(state_q));

endmodule

// File: tb/crc_multi_unit_tb.sv
module crc_multi_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  preset_sel;
    logic        verify_en, start, in_valid, last;
    logic [7:0]  in_data;
    logic [31:0] expect_crc;
    logic        in_ready, done, match, mismatch;
    logic [31:0] crc_out;

    always #4 clk = ~clk;

    crc_multi_unit u_dut (
        .clk(clk), .rst_n(rst_n), .preset_sel(preset_sel), .verify_en(verify_en),
        .start(start), .in_valid(in_valid), .in_data(in_data), .last(last),
        .in_ready(in_ready), .expect_crc(expect_crc), .crc_out(crc_out),
        .done(done), .match(match), .mismatch(mismatch)
    );

    typedef struct {
        logic [31:0] crc;
        logic        m;
        logic        mm;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [7:0]  frame[$];
    int          checks = 0;
    int          errors = 0;
    logic        done_prev = 1'b0;
    bit          finished = 1'b0;

    // Textbook bitwise model of each preset.
    function automatic logic [31:0] ref_crc(int p);
        logic [31:0] c, poly, init, xo, msk;
        int w;
        if (p == 0) begin
            c = 32'hFFFF_FFFF;
            foreach (frame[i]) begin
                c ^= {24'h0, frame[i]};
                for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
            end
            return ~c;
        end
        w    = (p == 1) ? 16 : 8;
        poly = (p == 1) ? 32'h1021 : (p == 2) ? 32'h1D : 32'h2F;
        init = (p == 1) ? 32'hFFFF : 32'hFF;
        xo   = (p == 1) ? 32'h0 : 32'hFF;
        msk  = (p == 1) ? 32'hFFFF : 32'hFF;
        c = init;
        foreach (frame[i]) begin
            c ^= {24'h0, frame[i]} << (w - 8);
            for (int k = 0; k < 8; k++)
                c = c[w-1] ? (((c << 1) ^ poly) & msk) : ((c << 1) & msk);
        end
        return c ^ xo;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_check_string();
        string s = "123456789";
        frame.delete();
        for (int i = 0; i < s.len(); i++) frame.push_back(s[i]);
    endtask

    // Driver: pushes the expected item, then runs one frame.
    // gap: bubble cycles before each byte; swap_at: byte index at which preset_sel is scrambled (-1 none).
    task automatic run_frame(input int p, input bit ver, input logic [31:0] exp,
                             input logic [31:0] want, input bit want_m, input string tag,
                             input int gap, input int swap_at);
        item_t it;
        it.crc = want; it.m = ver && want_m; it.mm = ver && !want_m; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        preset_sel = p[1:0]; verify_en = ver; start = 1'b1; expect_crc = exp;
        @(negedge clk);
        start = 1'b0;
        check(in_ready === 1'b1 && done === 1'b0, {"R7 ready after start ", tag}, {31'h0, in_ready}, 32'h1);
        foreach (frame[i]) begin
            for (int g = 0; g < gap; g++) begin
                in_valid = 1'b0; last = 1'b0;
                @(negedge clk);
            end
            if (i == swap_at) preset_sel = ~p[1:0];
            in_valid = 1'b1; in_data = frame[i]; last = (i == frame.size() - 1);
            @(negedge clk);
        end
        if (frame.size() == 0) begin
            last = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0; last = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: on each rising done, pop and compare.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && done === 1'b1 && done_prev !== 1'b1) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9 unexpected completion", crc_out, 32'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(crc_out === it.crc, it.tag, crc_out, it.crc);
                check(match === it.m && mismatch === it.mm, {it.tag, " R10/R11 flags"},
                      {30'h0, match, mismatch}, {30'h0, it.m, it.mm});
                check(in_ready === 1'b0, {it.tag, " R8 ready low after done"}, {31'h0, in_ready}, 32'h0);
            end
        end
        done_prev <= done;
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'h0, 32'h0);
        finish_run();
    end

    initial begin
        logic [31:0] held;
        rst_n = 1'b0; preset_sel = 2'd0; verify_en = 1'b0; start = 1'b0;
        in_valid = 1'b0; in_data = 8'h0; last = 1'b0; expect_crc = 32'h0;
        repeat (3) @(negedge clk);
        check(in_ready === 0 && done === 0 && match === 0 && mismatch === 0 && crc_out === 0,
              "R1 reset state", crc_out, 32'h0);
        rst_n = 1'b1;
        // R9: traffic before any start is ignored
        in_valid = 1'b1; in_data = 8'h5A; last = 1'b1;
        repeat (3) @(negedge clk);
        in_valid = 1'b0; last = 1'b0;
        @(negedge clk);
        check(done === 0 && crc_out === 0 && in_ready === 0, "R1/R9 idle after reset", crc_out, 32'h0);

        // R2..R5 check strings
        load_check_string();
        run_frame(0, 0, 0, 32'hCBF4_3926, 0, "R2 crc32 check", 0, -1);
        run_frame(1, 0, 0, 32'h0000_29B1, 0, "R3 ccitt check", 0, -1);
        run_frame(2, 0, 0, 32'h0000_004B, 0, "R4 j1850 check", 0, -1);
        run_frame(3, 0, 0, 32'h0000_00DF, 0, "R5 poly2f check", 0, -1);

        // R6 bubbles between bytes
        frame.delete();
        for (int i = 0; i < 20; i++) frame.push_back(8'(i * 37 + 3));
        for (int p = 0; p < 4; p++)
            run_frame(p, 0, 0, ref_crc(p), 0, "R6 bubbles", 2, -1);

        // R7 preset change mid-frame has no effect
        run_frame(1, 0, 0, ref_crc(1), 0, "R7 preset swap mid-frame", 0, 5);
        run_frame(0, 0, 0, ref_crc(0), 0, "R7 preset swap mid-frame", 1, 10);

        // R9 input after done is ignored
        held = crc_out;
        in_valid = 1'b1; in_data = 8'hC3; last = 1'b1;
        repeat (4) @(negedge clk);
        in_valid = 1'b0; last = 1'b0;
        @(negedge clk);
        check(crc_out === held && done === 1'b1, "R9 ignored after done", crc_out, held);

        // R10 verify, match and mismatch, upper expect bits ignored
        load_check_string();
        run_frame(2, 1, 32'hABCD_124B, 32'h4B, 1, "R10 match masked", 0, -1);
        run_frame(2, 1, 32'h0000_004A, 32'h4B, 0, "R10 mismatch", 0, -1);
        run_frame(0, 1, 32'hCBF4_3926, 32'hCBF4_3926, 1, "R10 crc32 match", 1, -1);
        run_frame(1, 1, 32'hFFFF_29B1, 32'h29B1, 1, "R10 ccitt match masked", 0, -1);
        run_frame(3, 1, 32'h0000_00DE, 32'hDF, 0, "R10 poly2f mismatch", 0, -1);

        // R12 empty frames
        frame.delete();
        run_frame(0, 0, 0, 32'h0, 0, "R12 empty crc32", 0, -1);
        run_frame(1, 0, 0, 32'hFFFF, 0, "R12 empty ccitt", 0, -1);
        run_frame(2, 0, 0, 32'h0, 0, "R12 empty j1850", 0, -1);
        run_frame(3, 1, 32'h0, 32'h0, 1, "R12 empty poly2f verify", 0, -1);

        // R7 start clears result and wins over last
        @(negedge clk);
        preset_sel = 2'd1; start = 1'b1; last = 1'b1;
        @(negedge clk);
        start = 1'b0; last = 1'b0;
        check(done === 0 && crc_out === 0 && in_ready === 1, "R7 start clears and wins", crc_out, 32'h0);
        frame.delete();
        frame.push_back(8'hA5);
        run_frame(1, 0, 0, ref_crc(1), 0, "R8 single byte", 0, -1);

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R8 all results observed", sb.size(), 0);
        finish_run();
    end

endmodule